// File: doc/BRIEF.md
# I2C Read Target with Clock Stretching

This block is a 7-bit-address I2C target that only serves read transfers. It passes both bus lines through two-flop synchronizers and finds START and STOP conditions on the synchronized copies. After a START it shifts in the address byte on SCL rising edges. When the byte matches its own address and the direction bit asks for a read, it holds SCL low before the acknowledge bit and raises a transmit request to the local host. It acknowledges only after the host has written a fresh byte, and then shifts that byte out MSB first. After each byte the master acknowledges, it stretches the clock again until the next byte is written. A master NACK ends the transfer.

The host sees events through a small prioritized vector code: NACK, START, STOP and transmit request. The START, STOP and NACK flags are cleared by dedicated pulse inputs. The transmit request is cleared by writing the transmit byte. The pads are open drain: the block never drives a line high, and only asserts a drive-low enable for each line.

Top module: `i2c_stretch_target`

## Requirements
- R1: The target address is the parameter OWN_ADDR (default 7'h48). A read to that address (address byte = {OWN_ADDR, 1'b1}) is acknowledged with SDA low, and every byte the master clocks out equals the byte the host wrote, sent MSB first.
- R2: The block changes its SDA drive only while SCL is low, and it samples every incoming bit (address bits and the master's ACK/NACK) on an SCL rising edge.
- R3: After a matching read address, SCL is held low from the falling edge of the eighth address bit until the host writes the transmit byte. Only then is SDA pulled low for the ACK and SCL released.
- R4: After the master acknowledges a byte (SDA low at the ninth rising edge), SCL is held low again from that bit's falling edge until the next transmit byte is written.
- R5: If the master answers a byte with NACK (SDA high at the ninth rising edge), SDA is released, the NACK flag is set and no further transmit request is raised before the next START.
- R6: An address that does not match, or a matching address with the direction bit 0 (write), gets no ACK: SDA stays released, SCL is never held, and the bus is ignored until the next START.
- R7: irq_vec shows the lowest pending code among NACK = 4, START = 6, STOP = 8 and transmit request = 12, and shows 0 when no flag is pending.
- R8: The START, STOP and NACK flags stay set until the host pulses clr_start, clr_stop or clr_nack respectively. The transmit-request flag is cleared by a tx_wr pulse.
- R9: A START (SDA falling while SCL is high), whether it is a repeated START or comes in the middle of an address, restarts address reception from bit 7. A STOP (SDA rising while SCL is high) returns the block to idle.
- R10: After reset, neither line is driven low and irq_vec is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level as seen at the pad |
| sda_i | input | 1 | SDA line level as seen at the pad |
| scl_drive_low | output | 1 | Open-drain enable: pull SCL low (clock stretch) |
| sda_drive_low | output | 1 | Open-drain enable: pull SDA low |
| tx_wr | input | 1 | One-cycle strobe that writes tx_data to the transmit buffer |
| tx_data | input | 8 | Transmit byte |
| clr_start | input | 1 | Clears the START flag |
| clr_stop | input | 1 | Clears the STOP flag |
| clr_nack | input | 1 | Clears the NACK flag |
| irq_vec | output | 4 | Prioritized event code (0, 4, 6, 8, 12) |

## Verification
A bus master model honours stretching by waiting for SCL to read high before it times each high phase. A host model answers the vector codes after a deliberate delay, so the stretched windows are long and can be measured. Multi-byte reads with bytes such as 8'h00, 8'hFF, 8'h81 and 8'h7E show whether the shift order and the bit boundaries are correct. A read of one byte with the host held off makes START and transmit request pending at the same time, and later NACK and STOP, which tells the priority order apart from the sticky and clear behaviour. Foreign addresses, write requests, a repeated START after a NACK and a START in the middle of an address show the difference between matching and ignoring, and check that every START resets the bit position.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int VEC_W  = 4;

    localparam logic [VEC_W-1:0] VEC_NONE  = 4'd0;
    localparam logic [VEC_W-1:0] VEC_NACK  = 4'd4;
    localparam logic [VEC_W-1:0] VEC_START = 4'd6;
    localparam logic [VEC_W-1:0] VEC_STOP  = 4'd8;
    localparam logic [VEC_W-1:0] VEC_TXREQ = 4'd12;

    typedef enum logic [2:0] {
        ST_IDLE,     // ignoring bus until START
        ST_ADDR,     // shifting address byte
        ST_STRETCH,  // SCL held, waiting for host byte
        ST_SETUP,    // SDA driven, SCL still held for setup time
        ST_ACK,      // driving ACK, SCL released
        ST_DATA,     // shifting data byte out
        ST_MACK,     // waiting for master ACK/NACK sample
        ST_MACKD     // master acked, waiting for falling edge
    } eng_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic scl_m;
        logic scl_s;
        logic scl_p;
        logic sda_m;
        logic sda_s;
        logic sda_p;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d       = q;
        d.scl_m = scl_i;
        d.scl_s = q.scl_m;
        d.scl_p = q.scl_s;
        d.sda_m = sda_i;
        d.sda_s = q.sda_m;
        d.sda_p = q.sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_s     = q.scl_s;
    assign sda_s     = q.sda_s;
    assign scl_rise  =  q.scl_s && !q.scl_p;
    assign scl_fall  = !q.scl_s &&  q.scl_p;
    assign start_det =  q.scl_s && q.scl_p && !q.sda_s &&  q.sda_p;
    assign stop_det  =  q.scl_s && q.scl_p &&  q.sda_s && !q.sda_p;

    // R9: a bus condition is only ever seen with SCL steady high
    p_cond_scl_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |-> (!scl_rise && !scl_fall));

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] OWN_ADDR  = 7'h48,
    parameter int                SETUP_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              tx_wr,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              scl_low,
    output logic              sda_low,
    output logic              ev_txreq,
    output logic              ev_nack
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam int TMR_W = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
    localparam logic [TMR_W-1:0] TMR_END  = TMR_W'(SETUP_CYC - 1);

    typedef struct packed {
        eng_state_e        st;
        logic [CNT_W-1:0]  bitcnt;
        logic [BYTE_W-1:0] sh;
        logic [TMR_W-1:0]  tmr;
        logic              ack_ph;
        logic [BYTE_W-1:0] buf_b;
        logic              buf_full;
    } eng_t;

    eng_t q, d;
    logic txreq_d, nack_d;

    always_comb begin
        d       = q;
        txreq_d = 1'b0;
        nack_d  = 1'b0;
        if (start_det) begin
            d.st     = ST_ADDR;
            d.bitcnt = '0;
        end else if (stop_det) begin
            d.st = ST_IDLE;
        end else begin
            unique case (q.st)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (scl_rise && q.bitcnt != LAST_BIT) begin
                        d.sh     = {q.sh[BYTE_W-2:0], sda_s};
                        d.bitcnt = q.bitcnt + 1'b1;
                    end
                    if (scl_fall && q.bitcnt == LAST_BIT) begin
                        if (q.sh[BYTE_W-1:1] == OWN_ADDR && q.sh[0]) begin
                            d.st     = ST_STRETCH;
                            d.ack_ph = 1'b1;
                            txreq_d  = 1'b1;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_STRETCH: begin
                    if (q.buf_full) begin
                        d.sh       = q.buf_b;
                        d.buf_full = 1'b0;
                        d.tmr      = '0;
                        d.st       = ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (q.tmr == TMR_END) begin
                        d.bitcnt = '0;
                        d.st     = q.ack_ph ? ST_ACK : ST_DATA;
                    end else begin
                        d.tmr = q.tmr + 1'b1;
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.ack_ph = 1'b0;
                        d.bitcnt = '0;
                        d.st     = ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (scl_rise) d.bitcnt = q.bitcnt + 1'b1;
                    if (scl_fall) begin
                        if (q.bitcnt == LAST_BIT) d.st = ST_MACK;
                        else                      d.sh = {q.sh[BYTE_W-2:0], 1'b0};
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        if (sda_s) begin
                            nack_d = 1'b1;
                            d.st   = ST_IDLE;
                        end else begin
                            d.st = ST_MACKD;
                        end
                    end
                end
                ST_MACKD: begin
                    if (scl_fall) begin
                        d.st     = ST_STRETCH;
                        d.ack_ph = 1'b0;
                        txreq_d  = 1'b1;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
        if (tx_wr) begin
            d.buf_b    = tx_data;
            d.buf_full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign scl_low  = (q.st == ST_STRETCH) || (q.st == ST_SETUP);
    assign sda_low  = (q.st == ST_ACK)
                   || (q.st == ST_SETUP &&  q.ack_ph)
                   || (q.st == ST_SETUP && !q.ack_ph && !q.sh[BYTE_W-1])
                   || (q.st == ST_DATA  && !q.sh[BYTE_W-1]);
    assign ev_txreq = txreq_d;
    assign ev_nack  = nack_d;

    // R2: SDA drive moves only while the synchronized SCL is low
    p_sda_moves_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_low) && !$past(start_det || stop_det)) |-> !$past(scl_s));

    // R3/R4: once stretching, SCL stays held until a byte is present
    p_hold_until_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_STRETCH && !q.buf_full && !tx_wr && !start_det && !stop_det)
        |=> scl_low);

    // R5: a NACK from the master leaves SDA released
    p_nack_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nack |=> !sda_low);

    // R9: every START restarts the address at bit 7
    p_start_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (q.st == ST_ADDR && q.bitcnt == '0));

    // R6: a transfer request is raised only after a full address byte
    p_req_after_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_txreq && q.st == ST_ADDR) |-> (q.sh[0] && q.bitcnt == LAST_BIT));

endmodule

// File: rtl/i2c_tgt_irq.sv
module i2c_tgt_irq
    import i2c_tgt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_start,
    input  logic             set_stop,
    input  logic             set_nack,
    input  logic             set_txreq,
    input  logic             clr_start,
    input  logic             clr_stop,
    input  logic             clr_nack,
    input  logic             tx_wr,
    output logic [VEC_W-1:0] irq_vec
);

    typedef struct packed {
        logic nack;
        logic start;
        logic stop;
        logic txreq;
    } flags_t;

    flags_t q, d;

    always_comb begin
        d = q;
        if (clr_start) d.start = 1'b0;
        if (clr_stop)  d.stop  = 1'b0;
        if (clr_nack)  d.nack  = 1'b0;
        if (tx_wr)     d.txreq = 1'b0;
        if (set_start) d.start = 1'b1;
        if (set_stop)  d.stop  = 1'b1;
        if (set_nack)  d.nack  = 1'b1;
        if (set_txreq) d.txreq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        if      (q.nack)  irq_vec = VEC_NACK;
        else if (q.start) irq_vec = VEC_START;
        else if (q.stop)  irq_vec = VEC_STOP;
        else if (q.txreq) irq_vec = VEC_TXREQ;
        else              irq_vec = VEC_NONE;
    end

    // R8: START flag stays until cleared
    p_start_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.start && !clr_start) |=> q.start);

    // R8: a transmit write removes the request code
    p_txreq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && !set_txreq) |=> (irq_vec != VEC_TXREQ));

    // R7: the request code shows only with no lower code pending
    p_txreq_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vec == VEC_TXREQ) |-> (!q.nack && !q.start && !q.stop));

    // R7: any pending flag gives a nonzero code
    p_vec_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q != '0) |-> (irq_vec != VEC_NONE));

endmodule

// File: rtl/i2c_stretch_target.sv
module i2c_stretch_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR  = 7'h48,
    parameter int         SETUP_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_drive_low,
    output logic       sda_drive_low,
    input  logic       tx_wr,
    input  logic [7:0] tx_data,
    input  logic       clr_start,
    input  logic       clr_stop,
    input  logic       clr_nack,
    output logic [3:0] irq_vec
);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic ev_txreq, ev_nack;

    i2c_line_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_engine #(
        .OWN_ADDR  (OWN_ADDR),
        .SETUP_CYC (SETUP_CYC)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .tx_wr     (tx_wr),
        .tx_data   (tx_data),
        .scl_low   (scl_drive_low),
        .sda_low   (sda_drive_low),
        .ev_txreq  (ev_txreq),
        .ev_nack   (ev_nack)
    );

    i2c_tgt_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_start (start_det),
        .set_stop  (stop_det),
        .set_nack  (ev_nack),
        .set_txreq (ev_txreq),
        .clr_start (clr_start),
        .clr_stop  (clr_stop),
        .clr_nack  (clr_nack),
        .tx_wr     (tx_wr),
        .irq_vec   (irq_vec)
    );

    // R10: nothing pulled low while in reset
    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |-> (!scl_drive_low && !sda_drive_low && irq_vec == 4'd0));

endmodule

// File: tb/i2c_stretch_target_tb.sv
module i2c_stretch_target_tb;

    localparam int HALF     = 40;
    localparam int HOST_DLY = 100;
    localparam int SCL_TMO  = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic       dut_scl_low, dut_sda_low;
    logic       scl_line, sda_line;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       clr_start = 1'b0, clr_stop = 1'b0, clr_nack = 1'b0;
    logic [3:0] irq_vec;

    int n_chk = 0, n_bad = 0;
    int loads = 0, seen_start = 0, seen_stop = 0, seen_nack = 0;
    int r2_viol = 0;
    int pat_idx = 0;
    bit host_auto = 1'b0;
    bit first_byte = 1'b0;
    bit saw_stretch = 1'b0;
    bit txn_done = 1'b0;
    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    logic [7:0] pats [8] = '{8'hA5, 8'h00, 8'hFF, 8'h81, 8'h7E, 8'h5A, 8'h01, 8'h80};

    always #4 clk = ~clk;

    assign scl_line = ~(m_scl_low | dut_scl_low);
    assign sda_line = ~(m_sda_low | dut_sda_low);

    i2c_stretch_target u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl_line),
        .sda_i         (sda_line),
        .scl_drive_low (dut_scl_low),
        .sda_drive_low (dut_sda_low),
        .tx_wr         (tx_wr),
        .tx_data       (tx_data),
        .clr_start     (clr_start),
        .clr_stop      (clr_stop),
        .clr_nack      (clr_nack),
        .irq_vec       (irq_vec)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R2 monitor: target SDA drive must hold while SCL stays high
    logic scl_prev = 1'b1, dsda_prev = 1'b0;
    always @(posedge clk) begin
        if (rst_n && scl_line && scl_prev && dut_sda_low != dsda_prev) r2_viol++;
        scl_prev  <= scl_line;
        dsda_prev <= dut_sda_low;
        if (dut_scl_low) saw_stretch <= 1'b1;
    end

    // scoreboard monitor: compare bytes received against bytes loaded
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0) begin
                logic [7:0] g, e;
                g = got_q.pop_front();
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 byte without load", int'(g), -1);
                end else begin
                    e = exp_q.pop_front();
                    check(g == e, "R1 byte", int'(g), int'(e));
                end
            end
        end
    end

    task automatic host_load(input logic [7:0] v);
        @(negedge clk);
        tx_data = v;
        tx_wr   = 1'b1;
        exp_q.push_back(v);
        loads++;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    // host responder acting on the vector code
    initial begin
        forever begin
            @(negedge clk);
            if (host_auto) begin
                case (irq_vec)
                    4'd4:  begin seen_nack++;  clr_nack  = 1'b1; @(negedge clk); clr_nack  = 1'b0; end
                    4'd6:  begin seen_start++; clr_start = 1'b1; @(negedge clk); clr_start = 1'b0; end
                    4'd8:  begin seen_stop++;  clr_stop  = 1'b1; @(negedge clk); clr_stop  = 1'b0; end
                    4'd12: begin
                        wait_cyc(HOST_DLY);
                        if (first_byte)
                            check(dut_scl_low && !scl_line, "R3 stretch before ACK", int'(scl_line), 0);
                        else
                            check(dut_scl_low && !scl_line, "R4 stretch between bytes", int'(scl_line), 0);
                        first_byte = 1'b0;
                        host_load(pats[pat_idx % 8]);
                        pat_idx++;
                    end
                    default: ;
                endcase
            end
        end
    end

    // ---------------- master model ----------------
    task automatic scl_up();
        int t;
        t = 0;
        m_scl_low = 1'b0;
        while (!scl_line && t < SCL_TMO) begin @(negedge clk); t++; end
        if (t >= SCL_TMO) check(1'b0, "R3 SCL never released", 0, 1);
    endtask

    task automatic scl_dn();
        m_scl_low = 1'b1;
        wait_cyc(4);
    endtask

    task automatic do_start();
        m_sda_low = 1'b0; wait_cyc(HALF);
        scl_up();         wait_cyc(HALF);
        m_sda_low = 1'b1; wait_cyc(HALF);
        scl_dn();         wait_cyc(HALF);
    endtask

    task automatic do_stop();
        m_sda_low = 1'b1; wait_cyc(HALF);
        scl_up();         wait_cyc(HALF);
        m_sda_low = 1'b0; wait_cyc(HALF);
    endtask

    task automatic send_bit(input logic b);
        m_sda_low = ~b; wait_cyc(HALF);
        scl_up();       wait_cyc(HALF);
        scl_dn();
    endtask

    task automatic read_bit(output logic b);
        m_sda_low = 1'b0; wait_cyc(HALF);
        scl_up();         wait_cyc(HALF / 2);
        b = sda_line;     wait_cyc(HALF / 2);
        scl_dn();
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic read_byte(output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin read_bit(b); v[i] = b; end
    endtask

    task automatic txn(input logic [6:0] a, input logic rw, input int n,
                       input bit exp_ack, input bit stop_after);
        logic b;
        logic [7:0] g;
        do_start();
        first_byte = 1'b1;
        send_byte({a, rw});
        read_bit(b);
        if (exp_ack) check(b == 1'b0, "R1 address ACK", int'(b), 0);
        else         check(b == 1'b1, "R6 no ACK", int'(b), 1);
        if (!b) begin
            for (int i = 0; i < n; i++) begin
                read_byte(g);
                got_q.push_back(g);
                send_bit(i == n - 1);
            end
        end
        if (stop_after) do_stop();
    endtask

    // ---------------- main sequence ----------------
    initial begin
        int l0, n0;
        wait_cyc(10);
        check(irq_vec == 4'd0, "R10 vec after reset", int'(irq_vec), 0);
        check(!dut_scl_low, "R10 SCL released", int'(dut_scl_low), 0);
        check(!dut_sda_low, "R10 SDA released", int'(dut_sda_low), 0);
        rst_n = 1'b1;
        wait_cyc(10);
        check(irq_vec == 4'd0 && !dut_scl_low && !dut_sda_low, "R10 idle after reset", int'(irq_vec), 0);

        // manual host: priority and clear behaviour
        fork
            begin txn(7'h48, 1'b1, 1, 1'b1, 1'b1); txn_done = 1'b1; end
        join_none
        wait (dut_scl_low == 1'b1);
        wait_cyc(30);
        check(!scl_line, "R3 SCL held awaiting data", int'(scl_line), 0);
        check(!dut_sda_low, "R3 no ACK before load", int'(dut_sda_low), 0);
        check(irq_vec == 4'd6, "R7 START ahead of request", int'(irq_vec), 6);
        clr_start = 1'b1; @(negedge clk); clr_start = 1'b0; @(negedge clk);
        check(irq_vec == 4'd12, "R7 request code", int'(irq_vec), 12);
        host_load(8'hC3);
        check(irq_vec == 4'd0, "R8 write clears request", int'(irq_vec), 0);
        wait (txn_done == 1'b1);
        wait_cyc(20);
        check(irq_vec == 4'd4, "R7 NACK ahead of STOP", int'(irq_vec), 4);
        clr_nack = 1'b1; @(negedge clk); clr_nack = 1'b0; @(negedge clk);
        check(irq_vec == 4'd8, "R8 STOP flag sticky", int'(irq_vec), 8);
        wait_cyc(50);
        check(irq_vec == 4'd8, "R8 STOP flag still set", int'(irq_vec), 8);
        clr_stop = 1'b1; @(negedge clk); clr_stop = 1'b0; @(negedge clk);
        check(irq_vec == 4'd0, "R8 all cleared", int'(irq_vec), 0);

        // automatic host: multi-byte read
        host_auto = 1'b1;
        l0 = loads; n0 = seen_nack;
        txn(7'h48, 1'b1, 5, 1'b1, 1'b1);
        wait_cyc(300);
        check(seen_nack - n0 == 1, "R5 NACK flag raised once", seen_nack - n0, 1);
        check(loads - l0 == 5, "R5 no request after NACK", loads - l0, 5);
        check(!dut_sda_low && !dut_scl_low, "R5 lines released", int'(dut_sda_low), 0);
        check(irq_vec == 4'd0, "R8 host cleared flags", int'(irq_vec), 0);

        // foreign address and write request
        saw_stretch = 1'b0; l0 = loads;
        txn(7'h49, 1'b1, 1, 1'b0, 1'b1);
        txn(7'h48, 1'b0, 1, 1'b0, 1'b1);
        wait_cyc(100);
        check(!saw_stretch, "R6 SCL never held", int'(saw_stretch), 0);
        check(loads == l0, "R6 no request", loads - l0, 0);

        // repeated START after NACK, and START inside an address
        l0 = loads;
        txn(7'h48, 1'b1, 1, 1'b1, 1'b0);
        do_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        txn(7'h48, 1'b1, 2, 1'b1, 1'b1);
        wait_cyc(300);
        check(loads - l0 == 3, "R9 restart served", loads - l0, 3);
        check(exp_q.size() == 0 && got_q.size() == 0, "R1 scoreboard drained",
              exp_q.size() + got_q.size(), 0);
        check(r2_viol == 0, "R2 SDA moved with SCL high", r2_viol, 0);
        check(seen_start >= 5 && seen_stop >= 4, "R9 START/STOP codes seen", seen_start, 5);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule